// File: doc/BRIEF.md
# Linked-List Summation Engine

This block walks a singly linked list kept in a byte-wide memory and adds up the signed 8-bit values held in its nodes. A pulse on `start` clears the internal link pointer and running total and begins the walk at address 0, which always holds the first node. Each node is two consecutive bytes. The byte at the node's own address is the link to the following node. The byte just after it is the node's value. A link of zero ends the list.

The memory has a single port with an asynchronous read, so only one byte is read per clock cycle. A small controller alternates between a value cycle and a link cycle. The datapath steers the read address between the pointer plus one and the pointer itself. When a zero link is read, the total is copied to `result` and `done` rises. Both hold their values until the next `start`.

Top module: `list_sum_engine`

## Requirements
- R1: After reset, `done` is 0 and `result` is 0.
- R2: On the clock edge where `start` is sampled high, the pointer and running total are cleared and a walk begins at the node at address 0. In the next cycle `mem_addr` is 1, the value byte of the head node, and `done` is 0.
- R3: `result` equals the sum of all node values taken modulo 256 (two's complement wraparound), and no overflow is flagged.
- R4: For each node at address P, one cycle reads address P+1 (the value) and the following cycle reads address P (the link). Exactly one address is presented per cycle.
- R5: The walk stops when a link byte of 0 is read. For a list of N nodes, `done` is 1 in the cycle that follows 2N clock edges after the `start` edge.
- R6: Once set, `done` stays 1 and `result` stays unchanged until `start` is sampled high, which clears `done` on that same edge.
- R7: Sampling `start` high while a walk is in progress abandons that walk and restarts from address 0.
- R8: Nodes may begin at any byte address, odd or even, and in any order. The value address P+1 wraps from 255 to 0.
- R9: `result` changes only on the edge that ends a walk. During a walk it keeps the previous total.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Clear state and begin a new walk from address 0 |
| mem_addr | output | 8 | Read address to the list memory |
| mem_rdata | input | 8 | Read data, valid in the same cycle as `mem_addr` |
| done | output | 1 | Walk finished; `result` is valid |
| result | output | 8 | Final modulo-256 sum of the node values |

## Verification
The hardest case to reach from the ports is a node whose value byte lies at address 0. This happens when a node sits at 255, so the same memory byte serves as both the head's link and the last node's value. The bench builds that list by hand and also sweeps list lengths, node strides and odd offsets, including lists laid out in descending address order. At every cycle it checks the address sequence against the node addresses it placed in memory. A restart is forced partway through a walk, so the abandoned total must not leak into `result`.

// File: rtl/lsum_pkg.sv
package lsum_pkg;
    localparam int LSUM_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_VAL  = 2'd1,
        ST_PTR  = 2'd2
    } lsum_state_e;

    typedef struct packed {
        lsum_state_e state;
        logic        done;
    } lsum_ctrl_t;
endpackage

// File: rtl/lsum_ctrl.sv
module lsum_ctrl
    import lsum_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic ptr_zero,
    output logic clear,
    output logic load_sum,
    output logic load_next,
    output logic finish,
    output logic sel_ptr,
    output logic done
);
    lsum_ctrl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d     = ctl_q;
        clear     = 1'b0;
        load_sum  = 1'b0;
        load_next = 1'b0;
        finish    = 1'b0;
        sel_ptr   = 1'b0;
        if (start) begin
            clear       = 1'b1;
            ctl_d.state = ST_VAL;
            ctl_d.done  = 1'b0;
        end else begin
            case (ctl_q.state)
                ST_VAL: begin
                    load_sum    = 1'b1;
                    ctl_d.state = ST_PTR;
                end
                ST_PTR: begin
                    sel_ptr   = 1'b1;
                    load_next = 1'b1;
                    if (ptr_zero) begin
                        finish      = 1'b1;
                        ctl_d.done  = 1'b1;
                        ctl_d.state = ST_IDLE;
                    end else begin
                        ctl_d.state = ST_VAL;
                    end
                end
                default: ctl_d.state = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.state <= ST_IDLE;
            ctl_q.done  <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign done = ctl_q.done;

    // R2: a start always launches a value fetch with done cleared
    p_launch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (ctl_q.state == ST_VAL && !done));

    // R4: a value fetch is always followed by a link fetch
    p_alternate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.state == ST_VAL && !start) |=> (ctl_q.state == ST_PTR));

    // R4: never load the total and the pointer from the same read
    p_one_access_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({load_sum, load_next}));

    // R5: a zero link ends the walk
    p_stop_on_null_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.state == ST_PTR && !start && ptr_zero) |=> (done && ctl_q.state == ST_IDLE));
endmodule

// File: rtl/lsum_datapath.sv
module lsum_datapath #(
    parameter int W = lsum_pkg::LSUM_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         load_sum,
    input  logic         load_next,
    input  logic         finish,
    input  logic         sel_ptr,
    input  logic [W-1:0] mem_rdata,
    output logic [W-1:0] mem_addr,
    output logic         ptr_zero,
    output logic [W-1:0] result
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [W-1:0] next;
        logic [W-1:0] sum;
        logic [W-1:0] res;
    } dp_regs_t;

    dp_regs_t dp_d, dp_q;

    always_comb begin
        dp_d = dp_q;
        if (clear) begin
            dp_d.next = '0;
            dp_d.sum  = '0;
        end else begin
            if (load_sum)  dp_d.sum  = dp_q.sum + mem_rdata;
            if (load_next) dp_d.next = mem_rdata;
            if (finish)    dp_d.res  = dp_q.sum;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dp_q <= '0;
        end else begin
            dp_q <= dp_d;
        end
    end

    assign mem_addr = sel_ptr ? dp_q.next : dp_q.next + ONE;
    assign ptr_zero = (mem_rdata == '0);
    assign result   = dp_q.res;

    // R9: the published total moves only when a walk ends
    p_result_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !finish |=> $stable(result));

    // R4: the link read sits one byte below the preceding value read
    p_link_below_value_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (load_sum && !clear) |=> (!sel_ptr || mem_addr == $past(mem_addr) - ONE));
endmodule

// File: rtl/list_sum_engine.sv
module list_sum_engine (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    output logic [7:0] mem_addr,
    input  logic [7:0] mem_rdata,
    output logic       done,
    output logic [7:0] result
);
    logic clear, load_sum, load_next, finish, sel_ptr, ptr_zero;

    lsum_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .ptr_zero  (ptr_zero),
        .clear     (clear),
        .load_sum  (load_sum),
        .load_next (load_next),
        .finish    (finish),
        .sel_ptr   (sel_ptr),
        .done      (done)
    );

    lsum_datapath #(.W(8)) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (clear),
        .load_sum  (load_sum),
        .load_next (load_next),
        .finish    (finish),
        .sel_ptr   (sel_ptr),
        .mem_rdata (mem_rdata),
        .mem_addr  (mem_addr),
        .ptr_zero  (ptr_zero),
        .result    (result)
    );

    // R6: completion and its total persist until the next start
    p_done_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(result)));
endmodule

// File: tb/list_sum_engine_test.sv
module list_sum_engine_test;
    localparam int CLK_PERIOD = 10;
    localparam int WD_LIMIT   = 100000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] mem_addr, mem_rdata, result;
    logic       done;

    logic [7:0] mem [256];
    logic [7:0] nodes [64];
    logic [7:0] vals  [64];

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    logic [7:0] last_res = 8'd0;

    assign mem_rdata = mem[mem_addr];

    always #(CLK_PERIOD/2) clk = ~clk;

    list_sum_engine uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .done(done), .result(result)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > WD_LIMIT) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, WD_LIMIT);
            finish_run();
        end
    end

    task automatic load_mem(input int n);
        for (int a = 0; a < 256; a++) mem[a] = 8'd0;
        for (int i = 0; i < n; i++)
            mem[nodes[i]] = (i == n-1) ? 8'd0 : nodes[i+1];
        for (int i = 0; i < n; i++)
            mem[8'(nodes[i] + 8'd1)] = vals[i];
    endtask

    // Ascending (dir=0) or descending (dir=1) layout with a given stride and offset
    task automatic build(input int n, input int stride, input int off, input int seed, input bit dir);
        nodes[0] = 8'd0;
        vals[0]  = 8'((seed * 53 + 7) & 255);
        for (int i = 1; i < n; i++) begin
            nodes[i] = dir ? 8'(250 - off - (i-1)*stride) : 8'(2 + off + (i-1)*stride);
            vals[i]  = 8'((i * 37 + seed * 11 + 200) & 255);
        end
        load_mem(n);
    endtask

    // abort_at > 0: start, let the walk run abort_at cycles, then restart (R7)
    task automatic run_list(input int n, input int abort_at);
        int exp_sum;
        exp_sum = 0;
        for (int i = 0; i < n; i++) exp_sum = (exp_sum + vals[i]) & 255;
        if (abort_at > 0) begin
            @(negedge clk) start = 1'b1;
            @(negedge clk) start = 1'b0;
            for (int k = 1; k < abort_at; k++) @(negedge clk);
            check(done == 1'b0, "R7 mid-walk done", done, 0);
        end
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        for (int i = 0; i < n; i++) begin
            check(mem_addr == 8'(nodes[i] + 8'd1), "R4 R8 value address", mem_addr, 8'(nodes[i] + 8'd1));
            if (i == 0) begin
                check(done == 1'b0, "R2 R6 done cleared by start", done, 0);
                check(mem_addr == 8'd1, "R2 R7 walk restarts at head", mem_addr, 1);
            end
            check(result == last_res, "R9 result held during walk", result, last_res);
            @(negedge clk);
            check(mem_addr == nodes[i], "R4 link address", mem_addr, nodes[i]);
            check(done == 1'b0, "R5 no early done", done, 0);
            @(negedge clk);
        end
        check(done == 1'b1, "R5 done after 2N cycles", done, 1);
        check(result == 8'(exp_sum), "R3 modulo-256 total", result, exp_sum);
        last_res = 8'(exp_sum);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check(done == 1'b1 && result == last_res, "R6 done and result hold", result, last_res);
        end
    endtask

    initial begin
        for (int a = 0; a < 256; a++) mem[a] = 8'd0;
        #(CLK_PERIOD * 2 + 1);
        check(done == 1'b0, "R1 reset done", done, 0);
        check(result == 8'd0, "R1 reset result", result, 0);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        check(done == 1'b0 && result == 8'd0, "R1 idle after reset", result, 0);

        // Sweep of lengths, strides, odd offsets and both orderings (R4 R5 R8)
        for (int n = 1; n <= 24; n++) begin
            build(n, 2 + (n % 5), n % 2, n, n[2]);
            run_list(n, 0);
        end

        // Wraparound: every value 0x80, sum wraps (R3)
        build(5, 3, 1, 0, 1'b0);
        for (int i = 0; i < 5; i++) vals[i] = 8'h80;
        load_mem(5);
        run_list(5, 0);

        // Node at 255 whose value byte is address 0 (R8)
        nodes[0] = 8'd0;   vals[0] = 8'd20;
        nodes[1] = 8'd255; vals[1] = 8'd255;
        load_mem(2);
        run_list(2, 0);

        // Restart mid-walk at several points (R7)
        for (int k = 1; k <= 5; k++) begin
            build(6, 4, 1, 40 + k, 1'b0);
            run_list(6, k);
        end

        finish_run();
    end
endmodule